// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under a per-element mask. In compress mode it walks the source elements in increasing index order and packs those whose mask bit is set into consecutive destination slots starting at slot 0. In expand mode it does the reverse: it takes source elements in order from index 0 and drops each one into the next destination slot whose mask bit is set.

A request carries the operation, the vector length and the mask, and is accepted on `start` while the unit is idle. The unit then handles one element per cycle. It reads the source register through a combinational read port and writes the destination register through a write port, both indexed by element. When the last element has been handled it pulses `done` and presents the number of selected elements on `packed_len`. Destination slots that receive no write keep whatever they held before.

Top module: `vmask_pack_unit`

## Requirements
- R1: With `op_expand`=0 (compress), the k-th selected source element in increasing index order is written to destination slot k, for k = 0, 1, 2 and so on.
- R2: When `done` is high, `packed_len` equals the number of set mask bits among elements 0 to VL-1. The value holds until the next accepted request and is 0 after reset. This applies to both operations.
- R3: With `op_expand`=1 (expand), source element k is written to the destination slot of the k-th set mask bit, counting set bits in increasing index order.
- R4: In expand, destination slots whose mask bit is clear keep their previous contents.
- R5: Mask bits at index VL or above are ignored. They cause no read, no write and no count.
- R6: In compress, destination slots at index `packed_len` or above keep their previous contents.
- R7: The unit handles one element per clock edge, starting at the first edge after the edge that accepts `start`. `done` is a one-cycle pulse raised at the edge that handles element VL-1, so it is visible VL cycles after acceptance. With VL=0 it is raised at the accepting edge. `busy` is high from acceptance until `done` rises.
- R8: A mask with no set bits inside VL gives `packed_len`=0 and no write.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes unchanged, and no second `done` follows.
- R10: A `vl` value above MAX_VL (64) is treated as MAX_VL.
- R11: After reset, `busy`, `done`, `wr_en` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op_expand | input | 1 | 0 = compress, 1 = expand |
| vl | input | 7 | Vector length of the request |
| mask | input | 64 | One selection bit per element |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| packed_len | output | 7 | Count of selected elements |
| rd_en | output | 1 | Source read strobe |
| rd_idx | output | 6 | Source element index |
| rd_data | input | 32 | Source element value for `rd_idx` (same cycle) |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 6 | Destination element index |
| wr_data | output | 32 | Destination element value |

## Verification
Acceptance happens at the edge that samples `start`. The bench counts falling edges from that point and requires `done` at exactly the VL-th falling edge, or at the 0th when VL is 0. It then watches four more cycles to confirm that no second pulse appears. Writes land at the edges between acceptance and `done`, so the model of the destination register is compared only after `done` has been seen. `packed_len` is read in the same cycle as `done`. All inputs change and all outputs are sampled on falling edges, half a period away from the edges where the unit updates.

// File: rtl/vmask_pack_unit.sv
module vmask_pack_unit #(
  parameter int MAX_VL = 64,
  parameter int DW = 32,
  localparam int IW = $clog2(MAX_VL),
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_expand,
  input  logic [VLW-1:0]    vl,
  input  logic [MAX_VL-1:0] mask,
  output logic              busy,
  output logic              done,
  output logic [VLW-1:0]    packed_len,
  output logic              rd_en,
  output logic [IW-1:0]     rd_idx,
  input  logic [DW-1:0]     rd_data,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [DW-1:0]     wr_data
);

  logic              busy_q, done_q, expand_q;
  logic [MAX_VL-1:0] mask_q;
  logic [IW-1:0]     elem_q, last_q;
  logic [VLW-1:0]    ptr_q, len_q;

  logic [VLW-1:0]    vl_eff, vl_m1;
  logic [MAX_VL-1:0] vl_ones;
  logic              sel;

  assign vl_eff  = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
  assign vl_m1   = vl_eff - 1'b1;
  assign vl_ones = {MAX_VL{1'b1}} >> (VLW'(MAX_VL) - vl_eff);
  assign sel     = busy_q & mask_q[elem_q];

  assign busy       = busy_q;
  assign done       = done_q;
  assign packed_len = len_q;
  assign rd_en      = sel;
  assign rd_idx     = expand_q ? ptr_q[IW-1:0] : elem_q;
  assign wr_en      = sel;
  assign wr_idx     = expand_q ? elem_q : ptr_q[IW-1:0];
  assign wr_data    = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      expand_q <= 1'b0;
      mask_q   <= '0;
      elem_q   <= '0;
      last_q   <= '0;
      ptr_q    <= '0;
      len_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          expand_q <= op_expand;
          mask_q   <= mask & vl_ones;
          elem_q   <= '0;
          ptr_q    <= '0;
          last_q   <= vl_m1[IW-1:0];
          if (vl_eff == '0) begin
            done_q <= 1'b1;
            len_q  <= '0;
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else begin
        if (sel) ptr_q <= ptr_q + 1'b1;
        if (elem_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          len_q  <= ptr_q + VLW'(sel);
        end else begin
          elem_q <= elem_q + 1'b1;
        end
      end
    end
  end

  assert_len_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> packed_len == VLW'($countones(mask_q)));

  assert_compress_packs_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !expand_q) |-> wr_idx <= rd_idx);

  assert_expand_spreads_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && expand_q) |-> rd_idx <= wr_idx);

  assert_write_only_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mask_q[expand_q ? wr_idx : rd_idx]);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_en && !rd_en));

  assert_done_excl_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: tb/vmask_pack_unit_tb_top.sv
`timescale 1ns/100ps
module vmask_pack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_expand = 1'b0;
  logic [6:0]  vl = '0;
  logic [63:0] mask = '0;
  logic        busy, done, rd_en, wr_en;
  logic [6:0]  packed_len;
  logic [5:0]  rd_idx, wr_idx;
  logic [31:0] rd_data, wr_data;

  logic [31:0] src [64];
  logic [31:0] dst [64];
  int wr_cnt = 0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vmask_pack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_expand(op_expand), .vl(vl),
    .mask(mask), .busy(busy), .done(done), .packed_len(packed_len),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  assign rd_data = src[rd_idx];

  always @(posedge clk) if (wr_en) begin
    dst[wr_idx] <= wr_data;
    wr_cnt = wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_dst();
    for (int i = 0; i < 64; i++) dst[i] = 32'hD000_0000 + i;
  endtask

  // poke >= 0: raise a competing start at that falling edge while busy (R9)
  task automatic run_op(input bit op, input logic [6:0] vl_in, input logic [63:0] m,
                        input string req, input int poke);
    logic [31:0] exp_d [64];
    int ve, p, cyc, w0, extra;
    bit seen;
    ve = (vl_in > 64) ? 64 : int'(vl_in);
    for (int i = 0; i < 64; i++) exp_d[i] = dst[i];
    p = 0;
    for (int i = 0; i < ve; i++) if (m[i]) begin
      if (op) exp_d[i] = src[p]; else exp_d[p] = src[i];
      p++;
    end
    @(negedge clk);
    w0 = wr_cnt;
    start = 1'b1; op_expand = op; vl = vl_in; mask = m;
    @(negedge clk);
    start = 1'b0; mask = ~m; vl = 7'd3; op_expand = ~op;
    cyc = 0; seen = 0;
    while (cyc < 200) begin
      if (done) begin seen = 1; break; end
      if (cyc == poke) begin start = 1'b1; vl = 7'd2; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(seen, req, "done seen", seen, 1);
    chk(cyc == ve, "R7", "done cycle", cyc, ve);
    chk(packed_len == 7'(p), "R2", "packed_len", packed_len, p);
    extra = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, (poke >= 0) ? "R9" : "R7", "extra done pulses", extra, 0);
    chk(wr_cnt - w0 == p, req, "write count", wr_cnt - w0, p);
    begin
      int bad;
      bad = -1;
      for (int i = 63; i >= 0; i--) if (dst[i] !== exp_d[i]) bad = i;
      if (bad >= 0) chk(0, req, $sformatf("dst[%0d]", bad), dst[bad], exp_d[bad]);
      else chk(1, req, "dst", 0, 0);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !wr_en && !rd_en, "R11", "idle outputs",
        {busy, done, wr_en, rd_en}, 0);
    chk(packed_len == 0, "R2", "reset packed_len", packed_len, 0);
  endtask

  task automatic t_compress_basic();  // R1 R6
    fill_dst();
    run_op(0, 7'd8, 64'hB2, "R1", -1);
    chk(dst[4] == 32'hD000_0004, "R6", "slot beyond len", dst[4], 32'hD000_0004);
  endtask

  task automatic t_compress_full();   // R1 R10
    fill_dst();
    run_op(0, 7'd100, 64'hF0F0_0F0F_1234_8001, "R10", -1);
  endtask

  task automatic t_expand_basic();    // R3 R4
    fill_dst();
    run_op(1, 7'd8, 64'hB2, "R3", -1);
    chk(dst[0] == 32'hD000_0000, "R4", "cleared slot kept", dst[0], 32'hD000_0000);
  endtask

  task automatic t_expand_wide();     // R3 R4
    fill_dst();
    run_op(1, 7'd64, 64'h8000_0000_0000_0001 | 64'h0F00_A500, "R4", -1);
  endtask

  task automatic t_vl_cut();          // R5
    fill_dst();
    run_op(0, 7'd5, 64'hFFFF_FFFF_FFFF_FFE4, "R5", -1);
    chk(dst[3] == 32'hD000_0003, "R5", "no write from high bits", dst[3], 32'hD000_0003);
  endtask

  task automatic t_zero_mask();       // R8
    fill_dst();
    run_op(1, 7'd20, 64'h0, "R8", -1);
    fill_dst();
    run_op(0, 7'd0, 64'hFFFF, "R8", -1);
  endtask

  task automatic t_busy_start();      // R9
    fill_dst();
    run_op(0, 7'd12, 64'hA5A, "R9", 3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) src[i] = 32'hA500_0000 + 32'(i * 7);
    fill_dst();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compress_basic();
    t_expand_basic();
    t_compress_full();
    t_expand_wide();
    t_vl_cut();
    t_zero_mask();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule